// File: doc/BRIEF.md
# Branch Target Buffer

This block is a small direct-mapped branch target buffer that the fetch stage reads with the current program counter. Each slot keeps a valid flag, the complete address of a branch as its tag, the target that branch last jumped to, and a 2-bit saturating confidence counter. The lookup is purely combinational. In the same cycle that a fetch address arrives, the block states whether that address is a known branch, whether it is predicted taken, and which address to fetch next. When it is not predicting a taken branch, the next address is the fetch address plus four.

A separate resolve port reports branch outcomes from later in the pipeline. A taken branch that has no slot is given one, and this replaces whatever lived at that index. A branch that already has a slot has its counter stepped toward the outcome, and a taken outcome also refreshes its stored target. An invalidate request removes a slot, but only when the stored tag equals the address given. All writes happen at the clock edge, so a lookup in the same cycle still sees the old contents.

Top module: `target_buffer`

## Requirements
- R1: After reset every slot is invalid, so `predHit` is 0 for any fetch address until an allocation occurs.
- R2: The slot is selected by `fetchPc[IDX_W+1:2]` (bits 5:2 for 16 slots). `predHit` is 1 in the same cycle only when that slot is valid and its stored tag equals all `PC_W` bits of `fetchPc`.
- R3: When `predHit` is 1 and the slot's counter is 2 or 3 (upper bit set), `predTaken` is 1 and `predNextPc` equals the stored target.
- R4: When `predTaken` is 0 (a miss, or a hit with counter 0 or 1), `predNextPc` equals `fetchPc + 4`.
- R5: `predTaken` is never 1 while `predHit` is 0.
- R6: A resolve with `resValid`=1, `resInvalidate`=0 and `resTaken`=1 whose `resPc` misses fills the slot: the slot becomes valid with tag `resPc`, target `resTarget` and counter 2 (weakly taken). The next lookup of `resPc` therefore hits and is predicted taken to `resTarget`.
- R7: A resolve that reports not taken for a `resPc` that misses leaves the buffer unchanged.
- R8: A resolve that hits steps the counter: +1 when taken and -1 when not taken, saturating at 3 and 0. A taken outcome also overwrites the stored target with `resTarget`.
- R9: A resolve with `resInvalidate`=1 clears the slot's valid flag when the stored tag equals `resPc`. When the tag differs, the slot is left unchanged.
- R10: Two addresses that share an index but differ elsewhere do not hit on each other's slot. Allocating the second one evicts the first.
- R11: A resolve changes lookup results starting at the cycle after its clock edge. A lookup of the same slot in the resolve's own cycle returns the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| fetchPc | input | PC_W | Address being fetched this cycle |
| predHit | output | 1 | Fetch address matches a valid slot |
| predTaken | output | 1 | Hit whose counter predicts taken |
| predNextPc | output | PC_W | Predicted next fetch address |
| resValid | input | 1 | A resolved branch is reported this cycle |
| resInvalidate | input | 1 | Remove the slot of `resPc` instead of training it |
| resTaken | input | 1 | Resolved direction, 1 means taken |
| resPc | input | PC_W | Address of the resolved branch |
| resTarget | input | PC_W | Actual target of the resolved branch |

## Verification
The three prediction outputs belong to the cycle in which `fetchPc` is applied. The bench therefore drives each vector on the falling edge and compares the outputs two time units later, before the next rising edge. A resolve is due exactly one rising edge after it is applied. Each table row checks the lookup against the contents left by the previous rows only, so any row whose fetch address equals its own resolve address confirms that the write is not yet visible. Counter saturation is shown by a pattern of rows whose outcome would change if the counter wrapped at 0 or at 3.

// File: rtl/tbuf_pkg.sv
package tbuf_pkg;
  localparam int CTR_W = 2;
  localparam logic [CTR_W-1:0] CTR_MAX = '1;
  localparam logic [CTR_W-1:0] CTR_MIN = '0;
  localparam logic [CTR_W-1:0] CTR_WEAK_TAKEN = 2'b10;

  // Strobes from control to datapath, all aimed at the resolve slot
  typedef struct packed {
    logic             clrValid;  // drop the slot
    logic             fill;      // write valid, tag, target and counter
    logic             bump;      // write counter only
    logic             wrTarget;  // write target only
    logic [CTR_W-1:0] ctrNext;   // counter value to write
  } tbufCmd_t;
endpackage

// File: rtl/tbuf_ctrl.sv
module tbuf_ctrl
  import tbuf_pkg::*;
(
  input  logic             resValid,
  input  logic             resInvalidate,
  input  logic             resTaken,
  input  logic             resHit,
  input  logic [CTR_W-1:0] resCtr,
  output tbufCmd_t         cmd
);
  logic [CTR_W-1:0] ctrUp;
  logic [CTR_W-1:0] ctrDown;

  assign ctrUp   = (resCtr == CTR_MAX) ? CTR_MAX : resCtr + 1'b1;
  assign ctrDown = (resCtr == CTR_MIN) ? CTR_MIN : resCtr - 1'b1;

  always_comb begin
    cmd = '0;
    if (resValid) begin
      if (resInvalidate) begin
        cmd.clrValid = resHit;
      end else if (resHit) begin
        cmd.bump     = 1'b1;
        cmd.ctrNext  = resTaken ? ctrUp : ctrDown;
        cmd.wrTarget = resTaken;
      end else if (resTaken) begin
        cmd.fill    = 1'b1;
        cmd.ctrNext = CTR_WEAK_TAKEN;
      end
    end
  end
endmodule

// File: rtl/tbuf_dpath.sv
module tbuf_dpath
  import tbuf_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int ENTRIES = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PC_W-1:0]  fetchPc,
  input  logic [PC_W-1:0]  resPc,
  input  logic [PC_W-1:0]  resTarget,
  input  tbufCmd_t         cmd,
  output logic             predHit,
  output logic             predTaken,
  output logic [PC_W-1:0]  predNextPc,
  output logic             resHit,
  output logic [CTR_W-1:0] resCtr
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int IDX_LO = 2;
  localparam int IDX_HI = IDX_LO + IDX_W - 1;

  logic             validQ [ENTRIES];
  logic [PC_W-1:0]  tagQ   [ENTRIES];
  logic [PC_W-1:0]  tgtQ   [ENTRIES];
  logic [CTR_W-1:0] ctrQ   [ENTRIES];

  logic [IDX_W-1:0] fetchIdx;
  logic [IDX_W-1:0] resIdx;

  assign fetchIdx = fetchPc[IDX_HI:IDX_LO];
  assign resIdx   = resPc[IDX_HI:IDX_LO];

  // Fetch-side lookup, combinational
  assign predHit    = validQ[fetchIdx] && (tagQ[fetchIdx] == fetchPc);
  assign predTaken  = predHit && ctrQ[fetchIdx][CTR_W-1];
  assign predNextPc = predTaken ? tgtQ[fetchIdx] : fetchPc + PC_W'(4);

  // Resolve-side lookup feeding the control
  assign resHit = validQ[resIdx] && (tagQ[resIdx] == resPc);
  assign resCtr = ctrQ[resIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) begin
        validQ[i] <= 1'b0;
        tagQ[i]   <= '0;
        tgtQ[i]   <= '0;
        ctrQ[i]   <= '0;
      end
    end else begin
      if (cmd.clrValid) validQ[resIdx] <= 1'b0;
      if (cmd.fill) begin
        validQ[resIdx] <= 1'b1;
        tagQ[resIdx]   <= resPc;
      end
      if (cmd.fill || cmd.wrTarget) tgtQ[resIdx] <= resTarget;
      if (cmd.fill || cmd.bump)     ctrQ[resIdx] <= cmd.ctrNext;
    end
  end
endmodule

// File: rtl/target_buffer.sv
module target_buffer
  import tbuf_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int ENTRIES = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PC_W-1:0] fetchPc,
  output logic            predHit,
  output logic            predTaken,
  output logic [PC_W-1:0] predNextPc,
  input  logic            resValid,
  input  logic            resInvalidate,
  input  logic            resTaken,
  input  logic [PC_W-1:0] resPc,
  input  logic [PC_W-1:0] resTarget
);
  tbufCmd_t         cmd;
  logic             resHit;
  logic [CTR_W-1:0] resCtr;

  tbuf_ctrl u_ctrl (
    .resValid      (resValid),
    .resInvalidate (resInvalidate),
    .resTaken      (resTaken),
    .resHit        (resHit),
    .resCtr        (resCtr),
    .cmd           (cmd)
  );

  tbuf_dpath #(.PC_W(PC_W), .ENTRIES(ENTRIES)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .fetchPc    (fetchPc),
    .resPc      (resPc),
    .resTarget  (resTarget),
    .cmd        (cmd),
    .predHit    (predHit),
    .predTaken  (predTaken),
    .predNextPc (predNextPc),
    .resHit     (resHit),
    .resCtr     (resCtr)
  );
endmodule

// File: rtl/tbuf_checker.sv
module tbuf_checker #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rstN,
  input logic [PC_W-1:0] fetchPc,
  input logic            predHit,
  input logic            predTaken,
  input logic [PC_W-1:0] predNextPc,
  input logic            resValid,
  input logic            resInvalidate,
  input logic            resTaken,
  input logic [PC_W-1:0] resPc,
  input logic [PC_W-1:0] resTarget
);
  AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !predHit); // R1

  AST_FALLTHROUGH: assert property (@(posedge clk) disable iff (!rstN)
    !predTaken |-> predNextPc == fetchPc + PC_W'(4)); // R4

  AST_TAKEN_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rstN)
    predTaken |-> predHit); // R5

  AST_TAKEN_ALLOCS: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && !resInvalidate && resTaken)
      |=> (fetchPc != $past(resPc)) || predHit); // R6

  AST_TAKEN_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && !resInvalidate && resTaken)
      |=> (fetchPc != $past(resPc)) || !predTaken || (predNextPc == $past(resTarget))); // R8

  AST_INVAL_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resInvalidate)
      |=> (fetchPc != $past(resPc)) || !predHit); // R9
endmodule

bind target_buffer tbuf_checker #(.PC_W(PC_W)) u_tbuf_checker (
  .clk           (clk),
  .rstN          (rstN),
  .fetchPc       (fetchPc),
  .predHit       (predHit),
  .predTaken     (predTaken),
  .predNextPc    (predNextPc),
  .resValid      (resValid),
  .resInvalidate (resInvalidate),
  .resTaken      (resTaken),
  .resPc         (resPc),
  .resTarget     (resTarget)
);

// File: tb/target_buffer_bench.sv
module target_buffer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W = 32;
  localparam int NVEC = 26;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [PC_W-1:0] fetchPc = '0;
  logic            predHit;
  logic            predTaken;
  logic [PC_W-1:0] predNextPc;
  logic            resValid = 1'b0;
  logic            resInvalidate = 1'b0;
  logic            resTaken = 1'b0;
  logic [PC_W-1:0] resPc = '0;
  logic [PC_W-1:0] resTarget = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  target_buffer #(.PC_W(PC_W), .ENTRIES(16)) u_target_buffer (
    .clk(clk), .rstN(rstN), .fetchPc(fetchPc),
    .predHit(predHit), .predTaken(predTaken), .predNextPc(predNextPc),
    .resValid(resValid), .resInvalidate(resInvalidate), .resTaken(resTaken),
    .resPc(resPc), .resTarget(resTarget)
  );

  // Row: fetch, resolve valid/invalidate/taken/pc/target, expected hit/taken/next, requirement
  typedef struct packed {
    logic [31:0] fpc;
    logic        rv;
    logic        ri;
    logic        rt;
    logic [31:0] rpc;
    logic [31:0] rtgt;
    logic        eh;
    logic        et;
    logic [31:0] en;
    logic [7:0]  req;
  } vec_t;

  // A=0x100 (slot 0), B=0x140 (slot 0, alias), C=0x104 (slot 1)
  localparam vec_t VECS [NVEC] = '{
    '{32'h100, 1'b1,1'b0,1'b1, 32'h100, 32'h2000, 1'b0,1'b0, 32'h104, 8'd11}, // R11 alloc not yet seen
    '{32'h100, 1'b0,1'b0,1'b0, 32'h0,   32'h0,    1'b1,1'b1, 32'h2000,8'd6},  // R6 weakly taken
    '{32'h100, 1'b1,1'b0,1'b0, 32'h100, 32'h0,    1'b1,1'b1, 32'h2000,8'd3},  // R3 ctr 2 -> 1
    '{32'h100, 1'b0,1'b0,1'b0, 32'h0,   32'h0,    1'b1,1'b0, 32'h104, 8'd4},  // R4 hit, not taken
    '{32'h100, 1'b1,1'b0,1'b0, 32'h100, 32'h0,    1'b1,1'b0, 32'h104, 8'd8},  // R8 ctr 1 -> 0
    '{32'h100, 1'b1,1'b0,1'b0, 32'h100, 32'h0,    1'b1,1'b0, 32'h104, 8'd8},  // R8 ctr stays 0
    '{32'h100, 1'b1,1'b0,1'b1, 32'h100, 32'h2400, 1'b1,1'b0, 32'h104, 8'd8},  // R8 ctr 0 -> 1
    '{32'h100, 1'b0,1'b0,1'b0, 32'h0,   32'h0,    1'b1,1'b0, 32'h104, 8'd8},  // R8 saturated at 0
    '{32'h100, 1'b1,1'b0,1'b1, 32'h100, 32'h2400, 1'b1,1'b0, 32'h104, 8'd8},  // R8 ctr 1 -> 2
    '{32'h100, 1'b1,1'b0,1'b1, 32'h100, 32'h2400, 1'b1,1'b1, 32'h2400,8'd8},  // R8 new target, ctr 3
    '{32'h100, 1'b1,1'b0,1'b1, 32'h100, 32'h2400, 1'b1,1'b1, 32'h2400,8'd8},  // R8 ctr stays 3
    '{32'h100, 1'b1,1'b0,1'b0, 32'h100, 32'h0,    1'b1,1'b1, 32'h2400,8'd8},  // R8 ctr 3 -> 2
    '{32'h100, 1'b0,1'b0,1'b0, 32'h0,   32'h0,    1'b1,1'b1, 32'h2400,8'd8},  // R8 saturated at 3
    '{32'h104, 1'b1,1'b0,1'b0, 32'h104, 32'h3000, 1'b0,1'b0, 32'h108, 8'd7},  // R7 not-taken miss
    '{32'h104, 1'b0,1'b0,1'b0, 32'h0,   32'h0,    1'b0,1'b0, 32'h108, 8'd7},  // R7 nothing allocated
    '{32'h140, 1'b0,1'b0,1'b0, 32'h0,   32'h0,    1'b0,1'b0, 32'h144, 8'd10}, // R10 alias misses
    '{32'h140, 1'b1,1'b0,1'b1, 32'h140, 32'h5000, 1'b0,1'b0, 32'h144, 8'd10}, // R10 alias allocates
    '{32'h140, 1'b0,1'b0,1'b0, 32'h0,   32'h0,    1'b1,1'b1, 32'h5000,8'd10}, // R10 alias now hits
    '{32'h100, 1'b0,1'b0,1'b0, 32'h0,   32'h0,    1'b0,1'b0, 32'h104, 8'd10}, // R10 old entry evicted
    '{32'h140, 1'b1,1'b1,1'b0, 32'h100, 32'h0,    1'b1,1'b1, 32'h5000,8'd9},  // R9 invalidate, wrong tag
    '{32'h140, 1'b0,1'b0,1'b0, 32'h0,   32'h0,    1'b1,1'b1, 32'h5000,8'd9},  // R9 entry kept
    '{32'h140, 1'b1,1'b1,1'b0, 32'h140, 32'h0,    1'b1,1'b1, 32'h5000,8'd11}, // R11 still visible
    '{32'h140, 1'b0,1'b0,1'b0, 32'h0,   32'h0,    1'b0,1'b0, 32'h144, 8'd9},  // R9 entry removed
    '{32'h104, 1'b1,1'b0,1'b1, 32'h104, 32'h3000, 1'b0,1'b0, 32'h108, 8'd6},  // R6 alloc slot 1
    '{32'h104, 1'b0,1'b0,1'b0, 32'h0,   32'h0,    1'b1,1'b1, 32'h3000,8'd6},  // R6 slot 1 hits
    '{32'h1104,1'b0,1'b0,1'b0, 32'h0,   32'h0,    1'b0,1'b0, 32'h1108,8'd2}   // R2 full tag compared
  };

  task automatic checkVal(input int req, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic applyAndCheck(input vec_t v);
    @(negedge clk);
    fetchPc       = v.fpc;
    resValid      = v.rv;
    resInvalidate = v.ri;
    resTaken      = v.rt;
    resPc         = v.rpc;
    resTarget     = v.rtgt;
    #2;
    checkVal(int'(v.req), "predHit",    {31'b0, predHit},   {31'b0, v.eh});
    checkVal(int'(v.req), "predTaken",  {31'b0, predTaken}, {31'b0, v.et});
    checkVal(int'(v.req), "predNextPc", predNextPc,         v.en);
    checkVal(5, "predTaken implies predHit", {31'b0, predTaken & ~predHit}, 32'h0); // R5
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    resValid = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    doReset();
    // R1: nothing hits right after reset
    #2;
    fetchPc = 32'h100;
    #1;
    checkVal(1, "predHit after reset", {31'b0, predHit}, 32'h0);
    checkVal(4, "predNextPc after reset", predNextPc, 32'h104);

    for (int i = 0; i < NVEC; i++) applyAndCheck(VECS[i]);

    // R1: reset in mid-run empties a filled slot (slot 1 holds 0x104)
    doReset();
    #2;
    fetchPc = 32'h104;
    #1;
    checkVal(1, "predHit after second reset", {31'b0, predHit}, 32'h0);
    checkVal(1, "predNextPc after second reset", predNextPc, 32'h108);

    // R2: a tag differing only in the top bit misses
    applyAndCheck('{32'h104, 1'b1,1'b0,1'b1, 32'h104, 32'h7000, 1'b0,1'b0, 32'h108, 8'd6});
    applyAndCheck('{32'h80000104, 1'b0,1'b0,1'b0, 32'h0, 32'h0, 1'b0,1'b0, 32'h80000108, 8'd2});
    applyAndCheck('{32'h104, 1'b0,1'b0,1'b0, 32'h0, 32'h0, 1'b1,1'b1, 32'h7000, 8'd3});

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule